// File: doc/BRIEF.md
# USB Endpoint Control and Status Register

This block holds the 8-bit control and status word of one endpoint of a USB device function. It sits between the transaction engine and the firmware. The transaction engine reports three kinds of event: a valid SETUP packet stored in the FIFO, the end of an OUT transaction, and an ACK received from the host. Alongside each event it supplies the endpoint type and, for control transfers, which stage just ended. In return the block gives the engine an accept or NAK decision for each OUT token, in the same cycle as the token strobe.

Firmware reads the whole word and writes it back. A write loads the control-write enable bit directly. For the three status bits, writing 0 clears the bit and writing 1 leaves it alone. A SETUP packet wins over everything else: it wipes the word down to its own flag. Pending OUT data is protected, because further OUT tokens are refused until firmware clears the pending flag. A level interrupt is raised while any status bit is set and its enable input is high.

Top module: `ep_csr_top`

## Requirements
- R1: After synchronous reset the word reads 0x00 and irq_o is low. Bits 6..3 always read 0, whatever is written.
- R2: Field positions: bit 7 is the control-write enable, bit 2 is SETUP received, bit 1 is OUT data pending, bit 0 is transfer complete. A firmware write (fw_wr_i high) loads bit 7 from fw_wdata_i[7]. A 0 in fw_wdata_i[2:0] clears the matching status bit, and a 1 leaves it unchanged.
- R3: A setup_evt_i pulse on a control endpoint sets bit 2 and clears every other bit, bit 7 included. The result is 0x04 on the next cycle, overriding any OUT, ACK or firmware write in the same cycle.
- R4: Accepting an OUT token sets bit 1 on the next cycle. out_ack_o is high in the same cycle as out_tok_i only when bit 1 is clear and, on a control endpoint, bit 7 is set. It is never high without out_tok_i.
- R5: A refused (NAKed) OUT token leaves the register unchanged.
- R6: ack_evt_i on a control endpoint sets bit 0 when stage_i is 1 (control-read data stage ended), 2 (status stage with no data stage) or 3 (status stage after a control write). stage_i = 0 has no effect.
- R7: Endpoint types are encoded on ep_kind_i as 0 control, 1 isochronous, 2 bulk and 3 interrupt. On types 1..3, setup_evt_i and ack_evt_i have no effect, and OUT data is accepted without bit 7.
- R8: When a hardware set and a firmware clear hit the same status bit in the same cycle, the bit ends up set.
- R9: irq_o is high exactly while some bit i in 0..2 of the word is set together with irq_en_i[i].
- R10: A status bit, once set, stays set until firmware clears it or a SETUP wipes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ep_kind_i | input | 2 | Endpoint type: 0 control, 1 iso, 2 bulk, 3 interrupt |
| setup_evt_i | input | 1 | Valid SETUP stored in FIFO (pulse) |
| out_tok_i | input | 1 | OUT transaction strobe needing a handshake decision |
| out_ack_o | output | 1 | 1 = ACK and store the OUT data, 0 = NAK (valid with out_tok_i) |
| ack_evt_i | input | 1 | Host ACK received (pulse) |
| stage_i | input | 2 | Control stage ended with that ACK: 0 other, 1 read data, 2 status no data, 3 status after write |
| fw_wr_i | input | 1 | Firmware write strobe |
| fw_wdata_i | input | 8 | Firmware write data |
| csr_o | output | 8 | Register contents |
| irq_en_i | input | 3 | Interrupt enables for bits 2..0 |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default 8-bit word, which is the only width the field layout allows. That width puts the control-write enable at the top bit and leaves reserved bits between it and the status bits, so the bench can show that writes to those bits read back as zero. The bench runs over all four endpoint types. That lets the control-only gating, the NAK-while-pending rule and the SETUP wipe be driven together with firmware writes that collide with them in the same cycle.

// File: rtl/ep_csr_pkg.sv
package ep_csr_pkg;
  localparam int CSR_W     = 8;
  localparam int NUM_STAT  = 3;
  localparam int TXC_POS   = 0;
  localparam int RXO_POS   = 1;
  localparam int SETUP_POS = 2;

  typedef enum logic [1:0] {
    EPK_CTRL = 2'd0,
    EPK_ISO  = 2'd1,
    EPK_BULK = 2'd2,
    EPK_INTR = 2'd3
  } ep_kind_e;

  typedef enum logic [1:0] {
    STG_OTHER      = 2'd0,
    STG_RD_DATA    = 2'd1,
    STG_STS_NODATA = 2'd2,
    STG_STS_WRITE  = 2'd3
  } ctl_stage_e;
endpackage

// File: rtl/ep_out_gate.sv
// Handshake decision for an OUT token, valid in the strobe cycle.
module ep_out_gate (
  input  logic is_ctrl_i,
  input  logic pending_i,
  input  logic cwe_i,
  input  logic out_tok_i,
  output logic accept_o
);
  always_comb begin
    accept_o = out_tok_i && !pending_i && (!is_ctrl_i || cwe_i);
  end
endmodule

// File: rtl/ep_event_decode.sv
// Turns transaction events into per-bit set strobes plus the SETUP wipe.
module ep_event_decode
  import ep_csr_pkg::*;
#(
  parameter int NS = NUM_STAT
) (
  input  logic [1:0]    kind_i,
  input  logic          setup_evt_i,
  input  logic          ack_evt_i,
  input  logic [1:0]    stage_i,
  input  logic          accept_i,
  output logic          is_ctrl_o,
  output logic          wipe_o,
  output logic [NS-1:0] set_o
);
  logic stage_hit;

  always_comb begin
    is_ctrl_o = (ep_kind_e'(kind_i) == EPK_CTRL);
    stage_hit = (ctl_stage_e'(stage_i) == STG_RD_DATA)
             || (ctl_stage_e'(stage_i) == STG_STS_NODATA)
             || (ctl_stage_e'(stage_i) == STG_STS_WRITE);
    wipe_o    = setup_evt_i && is_ctrl_o;
    set_o     = '0;
    set_o[SETUP_POS] = wipe_o;
    set_o[RXO_POS]   = accept_i && !wipe_o;
    set_o[TXC_POS]   = ack_evt_i && is_ctrl_o && stage_hit && !wipe_o;
  end
endmodule

// File: rtl/ep_status_cell.sv
// One sticky status flag: hardware set > SETUP wipe > firmware clear.
module ep_status_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic wipe_i,
  input  logic fw_clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)           q_o <= 1'b0;
    else if (set_i)    q_o <= 1'b1;
    else if (wipe_i)   q_o <= 1'b0;
    else if (fw_clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/ep_irq_mask.sv
// Masked OR of the status flags.
module ep_irq_mask #(
  parameter int NS = 3
) (
  input  logic [NS-1:0] stat_i,
  input  logic [NS-1:0] en_i,
  output logic          irq_o
);
  logic [NS-1:0] gated;

  for (genvar i = 0; i < NS; i++) begin : g_gate
    assign gated[i] = stat_i[i] & en_i[i];
  end

  assign irq_o = |gated;
endmodule

// File: rtl/ep_csr_top.sv
module ep_csr_top
  import ep_csr_pkg::*;
#(
  parameter int W = CSR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    ep_kind_i,
  input  logic          setup_evt_i,
  input  logic          out_tok_i,
  output logic          out_ack_o,
  input  logic          ack_evt_i,
  input  logic [1:0]    stage_i,
  input  logic          fw_wr_i,
  input  logic [W-1:0]  fw_wdata_i,
  output logic [W-1:0]  csr_o,
  input  logic [2:0]    irq_en_i,
  output logic          irq_o
);
  localparam int NS      = NUM_STAT;
  localparam int CWE_POS = W - 1;

  logic          is_ctrl;
  logic          wipe;
  logic          accept;
  logic          cwe_q;
  logic [NS-1:0] set_v;
  logic [NS-1:0] stat_q;
  logic [NS-1:0] fw_clr;

  ep_out_gate u_gate (
    .is_ctrl_i (is_ctrl),
    .pending_i (stat_q[RXO_POS]),
    .cwe_i     (cwe_q),
    .out_tok_i (out_tok_i),
    .accept_o  (accept)
  );

  ep_event_decode #(.NS(NS)) u_dec (
    .kind_i      (ep_kind_i),
    .setup_evt_i (setup_evt_i),
    .ack_evt_i   (ack_evt_i),
    .stage_i     (stage_i),
    .accept_i    (accept),
    .is_ctrl_o   (is_ctrl),
    .wipe_o      (wipe),
    .set_o       (set_v)
  );

  for (genvar i = 0; i < NS; i++) begin : g_stat
    assign fw_clr[i] = fw_wr_i && !fw_wdata_i[i];
    ep_status_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .set_i    (set_v[i]),
      .wipe_i   (wipe),
      .fw_clr_i (fw_clr[i]),
      .q_o      (stat_q[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)          cwe_q <= 1'b0;
    else if (wipe)    cwe_q <= 1'b0;
    else if (fw_wr_i) cwe_q <= fw_wdata_i[CWE_POS];
  end

  always_comb begin
    csr_o          = '0;
    csr_o[CWE_POS] = cwe_q;
    csr_o[NS-1:0]  = stat_q;
  end

  assign out_ack_o = accept;

  ep_irq_mask #(.NS(NS)) u_irq (
    .stat_i (stat_q),
    .en_i   (irq_en_i),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/ep_csr_chk.sv
module ep_csr_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] ep_kind_i,
  input logic       setup_evt_i,
  input logic       out_tok_i,
  input logic       out_ack_o,
  input logic       ack_evt_i,
  input logic       fw_wr_i,
  input logic [7:0] fw_wdata_i,
  input logic [7:0] csr_o,
  input logic       irq_o
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (csr_o == 8'h00));

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (rst)
    csr_o[6:3] == 4'b0000);

  assert_setup_wipe_R3: assert property (@(posedge clk) disable iff (rst)
    (setup_evt_i && ep_kind_i == 2'd0) |=> (csr_o == 8'h04));

  assert_nak_pending_R4: assert property (@(posedge clk) disable iff (rst)
    (out_tok_i && csr_o[1]) |-> !out_ack_o);

  assert_ack_needs_token_R4: assert property (@(posedge clk) disable iff (rst)
    !out_tok_i |-> !out_ack_o);

  assert_ctrl_needs_cwe_R4: assert property (@(posedge clk) disable iff (rst)
    (out_tok_i && ep_kind_i == 2'd0 && !csr_o[7]) |-> !out_ack_o);

  assert_nak_no_change_R5: assert property (@(posedge clk) disable iff (rst)
    (out_tok_i && !out_ack_o && !setup_evt_i && !ack_evt_i && !fw_wr_i)
      |=> $stable(csr_o));

  assert_noctrl_no_setup_R7: assert property (@(posedge clk) disable iff (rst)
    (ep_kind_i != 2'd0 && !csr_o[2]) |=> !csr_o[2]);

  assert_irq_source_R9: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (csr_o[2:0] != 3'b000));

  assert_sticky_out_R10: assert property (@(posedge clk) disable iff (rst)
    (csr_o[1] && !(fw_wr_i && !fw_wdata_i[1]) && !(setup_evt_i && ep_kind_i == 2'd0))
      |=> csr_o[1]);
endmodule

bind ep_csr_top ep_csr_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .ep_kind_i   (ep_kind_i),
  .setup_evt_i (setup_evt_i),
  .out_tok_i   (out_tok_i),
  .out_ack_o   (out_ack_o),
  .ack_evt_i   (ack_evt_i),
  .fw_wr_i     (fw_wr_i),
  .fw_wdata_i  (fw_wdata_i),
  .csr_o       (csr_o),
  .irq_o       (irq_o)
);

// File: tb/ep_csr_top_tb.sv
module ep_csr_top_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] kind = 2'd0;
  logic       setup = 1'b0;
  logic       tok = 1'b0;
  logic       ack;
  logic       ackevt = 1'b0;
  logic [1:0] stage = 2'd0;
  logic       wr = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [7:0] csr;
  logic [2:0] ien = 3'b000;
  logic       irq;

  int vectors = 0;
  int miscompares = 0;
  logic [7:0] m = 8'h00;

  always #5 clk = ~clk;

  ep_csr_top u_dut (
    .clk (clk), .rst (rst), .ep_kind_i (kind), .setup_evt_i (setup),
    .out_tok_i (tok), .out_ack_o (ack), .ack_evt_i (ackevt), .stage_i (stage),
    .fw_wr_i (wr), .fw_wdata_i (wd), .csr_o (csr), .irq_en_i (ien), .irq_o (irq)
  );

  task automatic cmp(input string tag, input string what, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic idle();
    setup = 0; tok = 0; ackevt = 0; stage = 0; wr = 0; wd = 0;
  endtask

  // Inputs for this cycle are set by the caller before calling cycle().
  task automatic cycle(input string tag);
    bit ctrl;
    bit exp_ack;
    logic [7:0] n;
    #1;
    ctrl    = (kind == 2'd0);
    exp_ack = tok && !m[1] && (!ctrl || m[7]);
    cmp(tag, "csr", csr, m);
    cmp(tag, "ack", ack, exp_ack);
    cmp(tag, "irq", irq, |(m[2:0] & ien));
    if (setup && ctrl) n = 8'h04;
    else begin
      n = m;
      if (wr) begin
        n[7] = wd[7];
        for (int i = 0; i < 3; i++) if (!wd[i]) n[i] = 1'b0;
      end
      if (exp_ack) n[1] = 1'b1;
      if (ackevt && ctrl && stage != 2'd0) n[0] = 1'b1;
    end
    m = n;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    m = 8'h00;
    idle(); cycle("R1");                       // reset state
    wr = 1; wd = 8'hFF; cycle("R2");           // sets bit7 only, reserved stay 0
    idle(); cycle("R1");
    tok = 1; cycle("R4");                      // ctrl, cwe=1: accepted
    idle(); ien = 3'b010; cycle("R4");         // bit1 now set
    tok = 1; cycle("R5");                      // pending -> NAK, unchanged
    idle(); cycle("R9");
    ien = 3'b101; cycle("R9");                 // masked off
    wr = 1; wd = 8'h80; cycle("R2");           // clear bit1, keep cwe
    wr = 1; wd = 8'h00; cycle("R2");           // clear cwe
    idle(); tok = 1; cycle("R5");              // ctrl without cwe -> NAK
    idle(); ackevt = 1; stage = 0; cycle("R6");
    for (int s = 1; s < 4; s++) begin
      idle(); ackevt = 1; stage = 2'(s); cycle("R6");
      idle(); cycle("R6");
      wr = 1; wd = 8'h00; cycle("R2");
    end
    idle(); ackevt = 1; stage = 1; wr = 1; wd = 8'h80; cycle("R8");  // set beats clear
    idle(); tok = 1; cycle("R4");
    idle(); setup = 1; tok = 1; wr = 1; wd = 8'h87; ackevt = 1; stage = 3; cycle("R3");
    idle(); cycle("R3");
    setup = 1; wr = 1; wd = 8'h00; cycle("R8");                      // setup beats clear
    idle(); cycle("R10");
    repeat (3) cycle("R10");
    wr = 1; wd = 8'h00; cycle("R2");
    kind = 2'd2; idle(); setup = 1; cycle("R7");
    idle(); ackevt = 1; stage = 2; cycle("R7");
    idle(); tok = 1; cycle("R7");                                     // no cwe needed
    idle(); cycle("R7");
    for (int k = 1; k < 4; k++) begin
      kind = 2'(k); wr = 1; wd = 8'h00; cycle("R7");
      idle(); setup = 1; tok = 1; cycle("R7");
      idle(); cycle("R7");
    end
    for (int c = 0; c < 3000; c++) begin
      idle();
      kind   = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
      setup  = ($urandom_range(0, 9) == 0);
      tok    = ($urandom_range(0, 2) == 0);
      ackevt = ($urandom_range(0, 3) == 0);
      stage  = 2'($urandom_range(0, 3));
      wr     = ($urandom_range(0, 3) == 0);
      wd     = 8'($urandom_range(0, 255));
      ien    = 3'($urandom_range(0, 7));
      cycle("R10");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule